// File: doc/BRIEF.md
# Kernel Cache Blend and Class-Split Argmax Unit

This unit serves one group of kernel tiles during iterative geometric training of a kernel classifier. It owns a single cache that holds, for every local training sample, the kernel value between the current solution point and that sample. A stream of freshly computed kernel values arrives one per clock, each tagged with its sample address. For each item the unit reads the cached value and blends it toward the new kernel value by a step weight λ, then writes the blended value back to the same entry.

The blended values pass through two running argmax trackers as they are written. A class bit stored beside each cache entry selects the tracker. One tracker follows the positive-class samples and the other follows the negative-class samples, because the next search point is the difference of the two class winners. When the pass ends, each local winner is compared with the matching winner from the upstream neighbouring group. The better of each pair is then issued with a one-cycle result strobe, and that output can feed the next group in the chain. Arithmetic is fixed point: kernel values are 16-bit signed and λ is unsigned Q1.15.

Top module: `kcache_argmax`

## Requirements
- R1: For λ below 1.0 (bit 15 of `in_lam` clear), the value written back is old + floor(λ_raw·(k − old) / 32768), where old is the entry's current value and k is `in_kern`.
- R2: When bit 15 of `in_lam` is set (λ of 1.0 or more), the entry is loaded with `in_kern` exactly, whatever its previous content.
- R3: One item is accepted every clock. An item sees the result of every earlier item to the same address, however closely the two follow each other.
- R4: Each address holds a class bit, written through `cls_we`/`cls_addr`/`cls_pos`, where 1 means positive and 0 means negative. An updated value competes only in the tracker of its own class.
- R5: Each class tracker keeps the largest updated value of the pass and its address. On equal values the lower address wins. A class that saw no item in the pass reports ok = 0.
- R6: An item with `in_first` set starts a new pass and discards both trackers' previous winners.
- R7: Per class, the local winner and the neighbour's candidate are merged. The larger value wins, equal values go to the lower 10-bit global address, and a side with ok = 0 always loses. A local global address is UNIT_ID·64 + local address, with UNIT_ID in the upper 4 bits.
- R8: `res_valid` pulses for one cycle only when both the local pass end and a neighbour result have been seen. It rises 2 cycles after an `nb_valid` pulse that completes the pair, or 4 cycles after the last stream item when the neighbour result was already held.
- R9: After reset, `res_valid` is 0, the result fields are 0, and no pass end or neighbour result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream item present |
| in_first | input | 1 | Item is the first of a pass |
| in_last | input | 1 | Item is the last of a pass |
| in_addr | input | 6 | Local sample address |
| in_kern | input | 16 | Fresh kernel value, signed |
| in_lam | input | 16 | Step weight, unsigned Q1.15 |
| cls_we | input | 1 | Class bit write enable |
| cls_addr | input | 6 | Class bit address |
| cls_pos | input | 1 | Class bit, 1 = positive |
| nb_valid | input | 1 | Neighbour result pulse |
| nb_pos_ok | input | 1 | Neighbour positive candidate valid |
| nb_pos_val | input | 16 | Neighbour positive value |
| nb_pos_addr | input | 10 | Neighbour positive global address |
| nb_neg_ok | input | 1 | Neighbour negative candidate valid |
| nb_neg_val | input | 16 | Neighbour negative value |
| nb_neg_addr | input | 10 | Neighbour negative global address |
| res_valid | output | 1 | Merged result strobe |
| res_pos_ok | output | 1 | Positive winner valid |
| res_pos_val | output | 16 | Positive winner value |
| res_pos_addr | output | 10 | Positive winner global address |
| res_neg_ok | output | 1 | Negative winner valid |
| res_neg_val | output | 16 | Negative winner value |
| res_neg_addr | output | 10 | Negative winner global address |

## Verification
The bench repeats one address at distances of one, two and three cycles. Missing forwarding would blend from a stale cache value, and the final winner value would then drift from the model. Single-item passes probe negative differences, where truncation toward zero instead of floor is off by one, and a λ of 0xFFFF, where a design that multiplies instead of loading gives a wrong entry. Equal values are placed both inside the unit and across the neighbour link, so a reversed tie rule reports the wrong address, and a class left empty exposes a tracker that reports a stale or zero winner as valid. The neighbour pulse is sent both before the stream and well after it. This catches a strobe that fires early, fires late, or fires on the local pass end alone.

// File: rtl/kc_pkg.sv
package kc_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 6;
    localparam int ID_W   = 4;
    localparam int LAM_W  = 16;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int GA_W   = ID_W + ADDR_W;
    localparam int FRAC_W = LAM_W - 1;
    localparam int STEP_W = DATA_W + 1;
    localparam int PROD_W = STEP_W + LAM_W + 1;

    typedef logic signed [DATA_W-1:0] kval_t;
    typedef logic signed [STEP_W-1:0] step_t;

    typedef struct packed {
        logic             ok;
        kval_t            val;
        logic [GA_W-1:0]  gaddr;
    } cand_t;

    // a strictly better than b: valid, larger, or equal and lower address
    function automatic logic beats(cand_t a, cand_t b);
        logic r;
        if (!a.ok)
            r = 1'b0;
        else if (!b.ok)
            r = 1'b1;
        else if ($signed(a.val) != $signed(b.val))
            r = $signed(a.val) > $signed(b.val);
        else
            r = a.gaddr < b.gaddr;
        return r;
    endfunction

    function automatic cand_t pick(cand_t a, cand_t b);
        return beats(a, b) ? a : b;
    endfunction

    // floor(lam * (k - old) / 2^FRAC_W)
    function automatic step_t blend_step(kval_t old, kval_t k, logic [LAM_W-1:0] lam);
        step_t                    diff;
        logic signed [PROD_W-1:0] prod;
        diff = STEP_W'(k) - STEP_W'(old);
        prod = PROD_W'(diff) * PROD_W'($signed({1'b0, lam}));
        return STEP_W'(prod >>> FRAC_W);
    endfunction
endpackage

// File: rtl/kc_cache_ram.sv
module kc_cache_ram
    import kc_pkg::*;
(
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output kval_t             rd_val,
    output logic              rd_cls,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  kval_t             wr_val,
    input  logic              cls_we,
    input  logic [ADDR_W-1:0] cls_addr,
    input  logic              cls_bit
);
    kval_t val_mem [DEPTH];
    logic  cls_mem [DEPTH];

    // synchronous read returns the pre-write content on a same-edge collision
    always_ff @(posedge clk) begin
        rd_val <= val_mem[rd_addr];
        rd_cls <= cls_mem[rd_addr];
        if (wr_en)
            val_mem[wr_addr] <= wr_val;
        if (cls_we)
            cls_mem[cls_addr] <= cls_bit;
    end
endmodule

// File: rtl/kc_class_best.sv
module kc_class_best
    import kc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_v,
    input  logic  in_first,
    input  logic  in_match,
    input  cand_t in_cand,
    output cand_t best_q,
    output cand_t best_d
);
    always_comb begin
        best_d = best_q;
        if (in_v && in_first)
            best_d = in_match ? in_cand : '0;
        else if (in_v && in_match && beats(in_cand, best_q))
            best_d = in_cand;
    end

    always_ff @(posedge clk) begin
        if (rst)
            best_q <= '0;
        else
            best_q <= best_d;
    end

    // R5: within a pass the held winner never gets smaller
    p_best_nondecreasing_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(best_q.ok) && !$past(in_v && in_first))
        |-> (best_q.ok && ($signed(best_q.val) >= $signed($past(best_q.val)))));

    // R4: an item of the other class never touches this tracker
    p_class_route_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(in_v && (in_match || in_first)) |-> (best_q == $past(best_q)));
endmodule

// File: rtl/kc_nb_merge.sv
module kc_nb_merge
    import kc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  loc_fire,
    input  cand_t loc_pos,
    input  cand_t loc_neg,
    input  logic  nb_valid,
    input  cand_t nb_pos,
    input  cand_t nb_neg,
    output logic  res_valid,
    output cand_t res_pos,
    output cand_t res_neg
);
    cand_t hold_pos, hold_neg, nbh_pos, nbh_neg;
    logic  loc_done, nb_done, emit;

    assign emit = loc_done && nb_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_pos   <= '0;
            res_neg   <= '0;
            hold_pos  <= '0;
            hold_neg  <= '0;
            nbh_pos   <= '0;
            nbh_neg   <= '0;
            loc_done  <= 1'b0;
            nb_done   <= 1'b0;
        end else begin
            res_valid <= emit;
            if (emit) begin
                res_pos <= pick(nbh_pos, hold_pos);
                res_neg <= pick(nbh_neg, hold_neg);
            end
            loc_done <= loc_fire || (loc_done && !emit);
            nb_done  <= nb_valid || (nb_done && !emit);
            if (loc_fire) begin
                hold_pos <= loc_pos;
                hold_neg <= loc_neg;
            end
            if (nb_valid) begin
                nbh_pos <= nb_pos;
                nbh_neg <= nb_neg;
            end
        end
    end

    // R7: the issued winner is never beaten by either contender it came from
    p_merge_pos_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (!beats($past(hold_pos), res_pos) && !beats($past(nbh_pos), res_pos)));
    p_merge_neg_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (!beats($past(hold_neg), res_neg) && !beats($past(nbh_neg), res_neg)));
endmodule

// File: rtl/kcache_argmax.sv
module kcache_argmax
    import kc_pkg::*;
#(
    parameter int UNIT_ID = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_kern,
    input  logic [LAM_W-1:0]  in_lam,
    input  logic              cls_we,
    input  logic [ADDR_W-1:0] cls_addr,
    input  logic              cls_pos,
    input  logic              nb_valid,
    input  logic              nb_pos_ok,
    input  logic [DATA_W-1:0] nb_pos_val,
    input  logic [GA_W-1:0]   nb_pos_addr,
    input  logic              nb_neg_ok,
    input  logic [DATA_W-1:0] nb_neg_val,
    input  logic [GA_W-1:0]   nb_neg_addr,
    output logic              res_valid,
    output logic              res_pos_ok,
    output logic [DATA_W-1:0] res_pos_val,
    output logic [GA_W-1:0]   res_pos_addr,
    output logic              res_neg_ok,
    output logic [DATA_W-1:0] res_neg_val,
    output logic [GA_W-1:0]   res_neg_addr
);
    localparam logic [ID_W-1:0] UID = ID_W'(UNIT_ID);

    // stage 1: cache read returning
    logic              s1_v, s1_first, s1_last, s1_load;
    logic [ADDR_W-1:0] s1_addr;
    kval_t             s1_kern, s1_old, ram_val;
    logic [LAM_W-1:0]  s1_lam;
    logic              ram_cls;
    // stage 2: blend finishes, write-back, tracking
    logic              s2_v, s2_first, s2_last, s2_load, s2_cls;
    logic [ADDR_W-1:0] s2_addr;
    kval_t             s2_old, s2_kern, s2_new;
    step_t             s2_step, s2_sum;
    // stage 3: value written on the previous edge
    logic              s3_v;
    logic [ADDR_W-1:0] s3_addr;
    kval_t             s3_val;

    kc_cache_ram u_ram (
        .clk      (clk),
        .rd_addr  (in_addr),
        .rd_val   (ram_val),
        .rd_cls   (ram_cls),
        .wr_en    (s2_v),
        .wr_addr  (s2_addr),
        .wr_val   (s2_new),
        .cls_we   (cls_we),
        .cls_addr (cls_addr),
        .cls_bit  (cls_pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s3_v <= 1'b0;
        end else begin
            s1_v <= in_valid;
            s2_v <= s1_v;
            s3_v <= s2_v;
        end
        s1_first <= in_first;
        s1_last  <= in_last;
        s1_addr  <= in_addr;
        s1_kern  <= kval_t'(in_kern);
        s1_lam   <= in_lam;
        s1_load  <= in_lam[LAM_W-1];

        s2_first <= s1_first;
        s2_last  <= s1_last;
        s2_addr  <= s1_addr;
        s2_kern  <= s1_kern;
        s2_load  <= s1_load;
        s2_cls   <= ram_cls;
        s2_old   <= s1_old;
        s2_step  <= blend_step(s1_old, s1_kern, s1_lam);

        s3_addr  <= s2_addr;
        s3_val   <= s2_new;
    end

    // youngest pending write to the same entry takes priority
    always_comb begin
        s1_old = ram_val;
        if (s3_v && s3_addr == s1_addr)
            s1_old = s3_val;
        if (s2_v && s2_addr == s1_addr)
            s1_old = s2_new;
    end

    assign s2_sum = STEP_W'(s2_old) + s2_step;
    assign s2_new = s2_load ? s2_kern : kval_t'(s2_sum);

    // R1: a partial step lands between the old value and the new kernel
    p_blend_bounded_r1: assert property (@(posedge clk) disable iff (rst)
        (s2_v && !s2_load) |->
        ((s2_old <= s2_kern) ? (s2_new >= s2_old && s2_new <= s2_kern)
                             : (s2_new <= s2_old && s2_new >= s2_kern)));

    cand_t s2_cand;
    cand_t best_q [2];
    cand_t best_d [2];

    assign s2_cand = '{ok: 1'b1, val: s2_new, gaddr: {UID, s2_addr}};

    // index 1 tracks the positive class, index 0 the negative class
    for (genvar g = 0; g < 2; g++) begin : g_cls
        kc_class_best u_best (
            .clk      (clk),
            .rst      (rst),
            .in_v     (s2_v),
            .in_first (s2_first),
            .in_match (s2_cls == 1'(g)),
            .in_cand  (s2_cand),
            .best_q   (best_q[g]),
            .best_d   (best_d[g])
        );
    end

    cand_t nb_pos_c, nb_neg_c, res_pos_c, res_neg_c;
    assign nb_pos_c = '{ok: nb_pos_ok, val: kval_t'(nb_pos_val), gaddr: nb_pos_addr};
    assign nb_neg_c = '{ok: nb_neg_ok, val: kval_t'(nb_neg_val), gaddr: nb_neg_addr};

    kc_nb_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .loc_fire  (s2_v && s2_last),
        .loc_pos   (best_d[1]),
        .loc_neg   (best_d[0]),
        .nb_valid  (nb_valid),
        .nb_pos    (nb_pos_c),
        .nb_neg    (nb_neg_c),
        .res_valid (res_valid),
        .res_pos   (res_pos_c),
        .res_neg   (res_neg_c)
    );

    assign res_pos_ok   = res_pos_c.ok;
    assign res_pos_val  = res_pos_c.val;
    assign res_pos_addr = res_pos_c.gaddr;
    assign res_neg_ok   = res_neg_c.ok;
    assign res_neg_val  = res_neg_c.val;
    assign res_neg_addr = res_neg_c.gaddr;
endmodule

// File: tb/kcache_argmax_tb.sv
module kcache_argmax_tb;
    localparam int TB_UID = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 0, in_first = 0, in_last = 0;
    logic [5:0]  in_addr = '0;
    logic [15:0] in_kern = '0, in_lam = '0;
    logic        cls_we = 0, cls_pos = 0;
    logic [5:0]  cls_addr = '0;
    logic        nb_valid = 0, nb_pos_ok = 0, nb_neg_ok = 0;
    logic [15:0] nb_pos_val = '0, nb_neg_val = '0;
    logic [9:0]  nb_pos_addr = '0, nb_neg_addr = '0;
    logic        res_valid, res_pos_ok, res_neg_ok;
    logic [15:0] res_pos_val, res_neg_val;
    logic [9:0]  res_pos_addr, res_neg_addr;

    always #5 clk = ~clk;

    kcache_argmax #(.UNIT_ID(TB_UID)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_addr(in_addr), .in_kern(in_kern), .in_lam(in_lam),
        .cls_we(cls_we), .cls_addr(cls_addr), .cls_pos(cls_pos),
        .nb_valid(nb_valid),
        .nb_pos_ok(nb_pos_ok), .nb_pos_val(nb_pos_val), .nb_pos_addr(nb_pos_addr),
        .nb_neg_ok(nb_neg_ok), .nb_neg_val(nb_neg_val), .nb_neg_addr(nb_neg_addr),
        .res_valid(res_valid),
        .res_pos_ok(res_pos_ok), .res_pos_val(res_pos_val), .res_pos_addr(res_pos_addr),
        .res_neg_ok(res_neg_ok), .res_neg_val(res_neg_val), .res_neg_addr(res_neg_addr)
    );

    typedef struct {
        bit pok; int pval; int pga;
        bit nok; int nval; int nga;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;
    int   cache_m [64];
    bit   cls_m [64];
    int   pa[$];
    int   pk[$];
    bit   done = 0;

    function automatic bit tb_beats(bit aok, int av, int ag, bit bok, int bv, int bg);
        if (!aok) return 0;
        if (!bok) return 1;
        if (av != bv) return av > bv;
        return ag < bg;
    endfunction

    task automatic chk(bit ok, string tag, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // monitor: pop the oldest expectation at every strobe
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8", "strobe with no pending result (got 1, expected 0)");
            end else begin
                exp_t e;
                bit   good;
                int   gpv, gnv;
                e = exp_q.pop_front();
                gpv = int'($signed(res_pos_val));
                gnv = int'($signed(res_neg_val));
                good = (res_pos_ok == e.pok) && (res_neg_ok == e.nok);
                if (e.pok) good = good && gpv == e.pval && int'(res_pos_addr) == e.pga;
                if (e.nok) good = good && gnv == e.nval && int'(res_neg_addr) == e.nga;
                chk(good, e.tag, $sformatf(
                    "actual pos(%0b,%0d,%0d) neg(%0b,%0d,%0d) expected pos(%0b,%0d,%0d) neg(%0b,%0d,%0d)",
                    res_pos_ok, gpv, res_pos_addr, res_neg_ok, gnv, res_neg_addr,
                    e.pok, e.pval, e.pga, e.nok, e.nval, e.nga));
            end
        end
    end

    task automatic pulse_nb(bit po, int pv, int pg, bit no, int nv, int ng);
        @(negedge clk);
        nb_valid = 1; nb_pos_ok = po; nb_pos_val = 16'(pv); nb_pos_addr = 10'(pg);
        nb_neg_ok = no; nb_neg_val = 16'(nv); nb_neg_addr = 10'(ng);
        @(negedge clk);
        nb_valid = 0;
    endtask

    // driver: model the pass, queue the expectation, then drive the ports
    task automatic run_pass(int lam, bit npo, int npv, int npg,
                            bit nno, int nnv, int nng, bit late, string tag);
        exp_t e;
        bit bpo = 0, bno = 0;
        int bpv = 0, bpg = 0, bnv = 0, bng = 0;
        foreach (pa[i]) begin
            int a, nv, ga;
            longint p;
            a = pa[i];
            if (lam >= 32768) nv = pk[i];
            else begin
                p  = longint'(pk[i] - cache_m[a]) * longint'(lam);
                nv = cache_m[a] + int'(p >>> 15);
            end
            cache_m[a] = nv;
            ga = TB_UID * 64 + a;
            if (cls_m[a]) begin
                if (tb_beats(1, nv, ga, bpo, bpv, bpg)) begin bpo = 1; bpv = nv; bpg = ga; end
            end else begin
                if (tb_beats(1, nv, ga, bno, bnv, bng)) begin bno = 1; bnv = nv; bng = ga; end
            end
        end
        if (tb_beats(npo, npv, npg, bpo, bpv, bpg)) begin bpo = npo; bpv = npv; bpg = npg; end
        if (tb_beats(nno, nnv, nng, bno, bnv, bng)) begin bno = nno; bnv = nnv; bng = nng; end
        e.pok = bpo; e.pval = bpv; e.pga = bpg;
        e.nok = bno; e.nval = bnv; e.nga = bng; e.tag = tag;
        exp_q.push_back(e);

        if (!late) pulse_nb(npo, npv, npg, nno, nnv, nng);
        foreach (pa[i]) begin
            @(negedge clk);
            in_valid = 1; in_first = (i == 0); in_last = (i == pa.size() - 1);
            in_addr = 6'(pa[i]); in_kern = 16'(pk[i]); in_lam = 16'(lam);
        end
        @(negedge clk);
        in_valid = 0; in_first = 0; in_last = 0;
        if (late) begin
            repeat (6) @(negedge clk);
            chk(exp_q.size() == 1, "R8",
                $sformatf("strobe before neighbour result (pending %0d, expected 1)", exp_q.size()));
            @(negedge clk);
            nb_valid = 1; nb_pos_ok = npo; nb_pos_val = 16'(npv); nb_pos_addr = 10'(npg);
            nb_neg_ok = nno; nb_neg_val = 16'(nnv); nb_neg_addr = 10'(nng);
            @(negedge clk);
            nb_valid = 0;
            chk(res_valid == 0, "R8", $sformatf("strobe 1 cycle after neighbour (got %0b, expected 0)", res_valid));
            @(negedge clk);
            chk(res_valid == 1, "R8", $sformatf("strobe 2 cycles after neighbour (got %0b, expected 1)", res_valid));
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        pa.delete();
        pk.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int p_lo, p_hi;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9: reset state
        chk(res_valid == 0 && res_pos_ok == 0 && res_neg_ok == 0 && res_pos_val == 0 && res_neg_addr == 0,
            "R9", $sformatf("after reset valid=%0b pos_ok=%0b neg_ok=%0b (expected all 0)",
                            res_valid, res_pos_ok, res_neg_ok));

        // R4: class bits, 1 = positive
        for (int a = 0; a < 64; a++) begin
            cls_m[a] = ((a * 5) % 7) >= 3;
            @(negedge clk);
            cls_we = 1; cls_addr = 6'(a); cls_pos = cls_m[a];
        end
        @(negedge clk);
        cls_we = 0;

        // R2 R4 R5: full load with lambda = 1.0, neighbour early and empty
        for (int a = 0; a < 64; a++) begin pa.push_back(a); pk.push_back(((a * 1237) % 4001) - 2000); end
        run_pass(32768, 0, 0, 0, 0, 0, 0, 0, "R2_load");

        // R1 R8: half step, neighbour late
        for (int a = 63; a >= 0; a--) begin pa.push_back(a); pk.push_back(((a * 911) % 6007) - 3000); end
        run_pass(16384, 1, 1500, 70, 1, -1800, 75, 1, "R1_half");

        // R3: same address at distance 1, 2 and 3
        pa = '{5, 5, 5, 9, 5, 9, 9, 12, 5};
        pk = '{1000, -3000, 7000, 500, -200, 8000, 8000, -100, 2500};
        run_pass(24576, 0, 0, 0, 0, 0, 0, 0, "R3_fwd");

        // R1: single item, negative difference exercises floor
        pa = '{20}; pk = '{-15001};
        run_pass(10923, 0, 0, 0, 0, 0, 0, 0, "R1_floor");

        // R2: lambda above 1.0 loads exactly
        pa = '{21}; pk = '{777};
        run_pass(65535, 0, 0, 0, 0, 0, 0, 1, "R2_sat");

        // R1: lambda zero leaves values unchanged
        for (int a = 0; a < 16; a++) begin pa.push_back(a); pk.push_back(19000); end
        run_pass(0, 0, 0, 0, 0, 0, 0, 0, "R1_zero");

        // R6: large winner, then a new pass with small values
        pa = '{30}; pk = '{20000};
        run_pass(32768, 0, 0, 0, 0, 0, 0, 0, "R6_prev");
        pa = '{31, 32, 33, 34, 35}; pk = '{-5, 12, -40, 3, 7};
        run_pass(32768, 0, 0, 0, 0, 0, 0, 0, "R6_restart");

        // R5: equal values inside the unit, higher address first
        p_lo = -1; p_hi = -1;
        for (int a = 40; a < 64; a++) if (cls_m[a]) begin
            if (p_lo < 0) p_lo = a; else if (p_hi < 0) p_hi = a;
        end
        pa = '{p_hi, p_lo}; pk = '{9999, 9999};
        run_pass(32768, 0, 0, 0, 0, 0, 0, 0, "R5_tie");

        // R7: equal value with a neighbour of lower and of higher unit id
        pa = '{p_lo}; pk = '{1234};
        run_pass(32768, 1, 1234, 64 + p_lo, 0, 0, 0, 0, "R7_tie_nb_wins");
        pa = '{p_lo}; pk = '{1234};
        run_pass(32768, 1, 1234, 320 + p_lo, 0, 0, 0, 1, "R7_tie_loc_wins");

        // R5 R7: negative class empty locally, filled or not by the neighbour
        pa = '{p_lo, p_hi}; pk = '{50, 60};
        run_pass(32768, 1, 40, 65, 1, -5, 70, 0, "R7_empty_cls");
        pa = '{p_lo, p_hi}; pk = '{-50, 60};
        run_pass(32768, 0, 0, 0, 0, 0, 0, 0, "R5_empty_cls");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule